// File: doc/BRIEF.md
# Calendar Alarm Comparator with Per-Field Masking

This block holds an alarm time and compares it against the BCD calendar counters of a real-time clock. The counters are kept outside the block and arrive on input pins. Each calendar field (seconds, minutes, hour, weekday, date, month and year) can be included in the comparison or masked out. A field that is masked out counts as a match. An alarm event occurs when every field that takes part in the comparison matches. The event sets a sticky flag in the status register. If the interrupt enable in the control register is set, the flag also drives the interrupt pin.

Software programs the block through a one-cycle register write strobe and reads it back through a combinational select port. Any write to an alarm register starts a settling window, and the new alarm takes part in the comparison only after a set number of periodic ticks. The expected software sequence is:
1. Clear the interrupt enable.
2. Rewrite the alarm registers.
3. Wait for the ticks.
4. Set the interrupt enable again.

The control and status pins are plain level or strobe signals. The block has no streaming data path, so no valid/ready handshake applies.

Top module: `cal_alarm_top`

## Requirements
- R1: After reset, every register select (0 to 9) reads 0x00 and `irq` is low.
- R2: Selects 0 to 5 (seconds, minutes, hour, weekday, date, month) each store a full byte. Bit 7 enables that field, and the low bits hold the BCD value at the width of the matching counter input (7, 7, 6, 3, 6 and 5 bits). Each byte reads back exactly as written.
- R3: A field whose enable is 0 counts as matched, whatever its counter value is.
- R4: Select 6 holds the 8-bit BCD year value. The year enable is bit 7 of select 7, which stores only bit 7 and reads its other bits as 0.
- R5: The flag (status select 8, bit 0) is set on the clock edge where the qualified match first becomes true. It reads 1 from the following cycle. It is not set again while the match merely persists.
- R6: Writing select 8 with bit 0 equal to 0 clears the flag. Writing it with bit 0 equal to 1 has no effect. If a new match and a clear arrive in the same cycle, the set wins.
- R7: Control select 9 stores only bit 0, the interrupt enable. `irq` is high exactly while the flag and the enable are both 1.
- R8: A write to any of selects 0 to 7 suppresses matching until `SETTLE_TICKS` (default 2) `tick` pulses have been counted after the write. A further alarm write restarts the count.
- R9: When no field enable is set, the flag is never set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle periodic tick pulse that paces the settling window |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 4 | Register select for the write |
| wr_data | input | 8 | Write data |
| rd_sel | input | 4 | Register select for the readback |
| rd_data | output | 8 | Readback data, combinational |
| cnt_sec | input | 7 | BCD seconds counter |
| cnt_min | input | 7 | BCD minutes counter |
| cnt_hour | input | 6 | BCD hour counter |
| cnt_wday | input | 3 | Weekday counter |
| cnt_mday | input | 6 | BCD date counter |
| cnt_mon | input | 5 | BCD month counter |
| cnt_year | input | 8 | BCD year counter |
| irq | output | 1 | Alarm interrupt, level |

## Verification
Suppose the block holds a wrong internal state:
- A stuck or mis-cleared edge register shows as a flag that never rises, or that rises again right after a clear while the counters still match. The status readback shows this one cycle after the offending edge.
- A settle counter that loads or counts wrongly moves the flag by whole tick intervals, so the flag appears after one tick instead of two, or never.
- A wrong enable decode shows as a flag that depends on a field which should be masked out.

The bench places each observation on the first cycle where the error would be visible.

// File: rtl/cal_alarm_pkg.sv
package cal_alarm_pkg;
  localparam int NUM_FIELDS = 7;
  localparam int REG_W      = 8;
  localparam int SEL_W      = 4;

  typedef enum logic [SEL_W-1:0] {
    SEL_SEC  = 4'd0,
    SEL_MIN  = 4'd1,
    SEL_HOUR = 4'd2,
    SEL_WDAY = 4'd3,
    SEL_MDAY = 4'd4,
    SEL_MON  = 4'd5,
    SEL_YEAR = 4'd6,
    SEL_YEN  = 4'd7,
    SEL_STAT = 4'd8,
    SEL_CTRL = 4'd9
  } reg_sel_e;

  // Width of each comparable field, indexed like the alarm selects 0..6.
  function automatic int field_width(input int idx);
    case (idx)
      0, 1:    return 7;
      2, 4:    return 6;
      3:       return 3;
      5:       return 5;
      default: return 8;
    endcase
  endfunction
endpackage

// File: rtl/alm_field_cmp.sv
module alm_field_cmp #(
  parameter int W = 7
) (
  input  logic         en,
  input  logic [W-1:0] alarm_val,
  input  logic [W-1:0] count_val,
  output logic         hit
);
  // A masked field never blocks the match.
  assign hit = !en || (alarm_val == count_val);
endmodule

// File: rtl/alm_settle.sv
module alm_settle #(
  parameter int TICKS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic tick,
  output logic busy
);
  localparam int CW = $clog2(TICKS + 1);
  localparam logic [CW-1:0] LOAD = CW'(TICKS);

  logic [CW-1:0] remain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      remain_q <= '0;
    else if (restart)
      remain_q <= LOAD;
    else if (tick && remain_q != '0)
      remain_q <= remain_q - 1'b1;
  end

  assign busy = (remain_q != '0);
endmodule

// File: rtl/alm_flag.sv
module alm_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic match,
  input  logic clr,
  output logic flag
);
  logic match_q;
  logic rise;

  assign rise = match && !match_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      match_q <= 1'b0;
      flag    <= 1'b0;
    end else begin
      match_q <= match;
      if (rise)
        flag <= 1'b1;
      else if (clr)
        flag <= 1'b0;
    end
  end
endmodule

// File: rtl/cal_alarm_top.sv
module cal_alarm_top
  import cal_alarm_pkg::*;
#(
  parameter int SETTLE_TICKS = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic [REG_W-1:0] wr_data,
  input  logic [SEL_W-1:0] rd_sel,
  output logic [REG_W-1:0] rd_data,
  input  logic [6:0]       cnt_sec,
  input  logic [6:0]       cnt_min,
  input  logic [5:0]       cnt_hour,
  input  logic [2:0]       cnt_wday,
  input  logic [5:0]       cnt_mday,
  input  logic [4:0]       cnt_mon,
  input  logic [7:0]       cnt_year,
  output logic             irq
);
  localparam int NUM_ALM = NUM_FIELDS + 1;

  logic [REG_W-1:0]      alm_q [NUM_ALM];
  logic                  aie_q;
  logic                  flag_q;
  logic [REG_W-1:0]      cnt_vec [NUM_FIELDS];
  logic [NUM_FIELDS-1:0] en_vec;
  logic [NUM_FIELDS-1:0] hit_vec;
  logic                  any_en;
  logic                  settle_busy;
  logic                  alm_wr;
  logic                  stat_clr;
  logic                  match;

  assign cnt_vec[0] = {1'b0, cnt_sec};
  assign cnt_vec[1] = {1'b0, cnt_min};
  assign cnt_vec[2] = {2'b0, cnt_hour};
  assign cnt_vec[3] = {5'b0, cnt_wday};
  assign cnt_vec[4] = {2'b0, cnt_mday};
  assign cnt_vec[5] = {3'b0, cnt_mon};
  assign cnt_vec[6] = cnt_year;

  assign alm_wr   = wr_en && (wr_sel < SEL_W'(NUM_ALM));
  assign stat_clr = wr_en && (wr_sel == SEL_STAT) && !wr_data[0];

  // Alarm register file: the year enable select keeps only its top bit.
  genvar gi;
  generate
    for (gi = 0; gi < NUM_ALM; gi++) begin : g_alm
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          alm_q[gi] <= '0;
        else if (wr_en && wr_sel == SEL_W'(gi))
          alm_q[gi] <= (gi == int'(SEL_YEN)) ? {wr_data[7], 7'b0} : wr_data;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      aie_q <= 1'b0;
    else if (wr_en && wr_sel == SEL_CTRL)
      aie_q <= wr_data[0];
  end

  // One comparator per calendar field, width taken from the package.
  generate
    for (gi = 0; gi < NUM_FIELDS; gi++) begin : g_cmp
      localparam int FW = field_width(gi);
      if (gi == NUM_FIELDS - 1) begin : g_year
        assign en_vec[gi] = alm_q[SEL_YEN][7];
      end else begin : g_std
        assign en_vec[gi] = alm_q[gi][7];
      end
      alm_field_cmp #(.W(FW)) u_cmp (
        .en        (en_vec[gi]),
        .alarm_val (alm_q[gi][FW-1:0]),
        .count_val (cnt_vec[gi][FW-1:0]),
        .hit       (hit_vec[gi])
      );
    end
  endgenerate

  assign any_en = |en_vec;

  alm_settle #(.TICKS(SETTLE_TICKS)) u_settle (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (alm_wr),
    .tick    (tick),
    .busy    (settle_busy)
  );

  assign match = (&hit_vec) && any_en && !settle_busy;

  alm_flag u_flag (
    .clk   (clk),
    .rst_n (rst_n),
    .match (match),
    .clr   (stat_clr),
    .flag  (flag_q)
  );

  assign irq = flag_q && aie_q;

  always_comb begin
    rd_data = '0;
    if (rd_sel < SEL_W'(NUM_ALM))
      rd_data = alm_q[rd_sel[2:0]];
    else if (rd_sel == SEL_STAT)
      rd_data = {7'b0, flag_q};
    else if (rd_sel == SEL_CTRL)
      rd_data = {7'b0, aie_q};
  end
endmodule

// File: rtl/cal_alarm_chk.sv
module cal_alarm_chk
  import cal_alarm_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [SEL_W-1:0] wr_sel,
  input logic [REG_W-1:0] wr_data,
  input logic             flag,
  input logic             aie,
  input logic             irq,
  input logic             settle_busy,
  input logic             any_en
);
  // R5: the flag stays set unless a clearing write arrives
  p_flag_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !(wr_en && wr_sel == SEL_STAT && !wr_data[0])) |=> flag);

  // R6: the flag only drops after a clearing write
  p_clear_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag) |-> $past(wr_en && wr_sel == SEL_STAT && !wr_data[0]));

  // R7: writing a zero enable silences the interrupt on the next cycle
  p_irq_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == SEL_CTRL && !wr_data[0]) |=> !irq);

  // R8: no new flag while the settling window is open
  p_settle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(!settle_busy));

  // R9: no flag without at least one enabled field
  p_need_en_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(any_en));

  // R7: the interrupt never shows without the enable latched
  p_irq_aie_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> aie);
endmodule

bind cal_alarm_top cal_alarm_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .wr_en       (wr_en),
  .wr_sel      (wr_sel),
  .wr_data     (wr_data),
  .flag        (flag_q),
  .aie         (aie_q),
  .irq         (irq),
  .settle_busy (settle_busy),
  .any_en      (any_en)
);

// File: tb/sim_cal_alarm_top.sv
`timescale 1ns/1ps
module sim_cal_alarm_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       wr_en = 1'b0;
  logic [3:0] wr_sel = '0;
  logic [7:0] wr_data = '0;
  logic [3:0] rd_sel = '0;
  logic [7:0] rd_data;
  logic [6:0] cnt_sec = 7'h29;
  logic [6:0] cnt_min = 7'h15;
  logic [5:0] cnt_hour = 6'h08;
  logic [2:0] cnt_wday = 3'd2;
  logic [5:0] cnt_mday = 6'h11;
  logic [4:0] cnt_mon = 5'h04;
  logic [7:0] cnt_year = 8'h23;
  logic       irq;

  int n_vec = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  cal_alarm_top u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data),
    .cnt_sec(cnt_sec), .cnt_min(cnt_min), .cnt_hour(cnt_hour),
    .cnt_wday(cnt_wday), .cnt_mday(cnt_mday), .cnt_mon(cnt_mon),
    .cnt_year(cnt_year), .irq(irq)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] s, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] s, output logic [7:0] d);
    rd_sel = s;
    #1;
    d = rd_data;
  endtask

  task automatic pulse_tick();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic flag_is(input string req, input logic e);
    logic [7:0] v;
    rd(4'd8, v);
    check(req, v, {7'b0, e});
  endtask

  task automatic t_reset();
    logic [7:0] v;
    for (int s = 0; s < 10; s++) begin
      rd(4'(s), v);
      check("R1 reset readback", v, 8'h00);
    end
    check("R1 reset irq", {7'b0, irq}, 8'h00);
  endtask

  task automatic t_regs();
    logic [7:0] v;
    wr(4'd0, 8'hA5); rd(4'd0, v); check("R2 sec byte", v, 8'hA5);
    wr(4'd3, 8'h85); rd(4'd3, v); check("R2 wday byte", v, 8'h85);
    wr(4'd5, 8'h12); rd(4'd5, v); check("R2 month byte", v, 8'h12);
    wr(4'd6, 8'h99); rd(4'd6, v); check("R4 year value", v, 8'h99);
    wr(4'd7, 8'hFF); rd(4'd7, v); check("R4 year enable bit7 only", v, 8'h80);
    wr(4'd9, 8'hFE); rd(4'd9, v); check("R7 ctrl bit0 only", v, 8'h00);
    for (int s = 0; s < 8; s++) wr(4'(s), 8'h00);
    pulse_tick(); pulse_tick(); idle(1);
    flag_is("R9 all masked", 1'b0);
  endtask

  task automatic t_match();
    wr(4'd0, 8'hB0);            // seconds enabled, value 0x30
    pulse_tick(); pulse_tick(); idle(1);
    flag_is("R5 no flag before match", 1'b0);
    cnt_sec = 7'h30;            // other fields unmasked? no: masked, differ freely
    @(negedge clk);
    flag_is("R5 flag one cycle after match", 1'b1);
    flag_is("R3 masked fields ignored", 1'b1);
    check("R7 irq off while enable clear", {7'b0, irq}, 8'h00);
    wr(4'd9, 8'h01);
    check("R7 irq on", {7'b0, irq}, 8'h01);
    wr(4'd8, 8'h01);
    flag_is("R6 write one keeps flag", 1'b1);
    wr(4'd8, 8'h00);
    check("R7 irq drops with flag", {7'b0, irq}, 8'h00);
    idle(3);
    flag_is("R5 no re-set while match persists", 1'b0);
    cnt_sec = 7'h31; @(negedge clk);
    cnt_sec = 7'h30; @(negedge clk);
    flag_is("R5 new match edge", 1'b1);
    wr(4'd9, 8'h00);
    check("R7 irq off after disable", {7'b0, irq}, 8'h00);
    wr(4'd8, 8'h00);
    flag_is("R6 clear", 1'b0);
  endtask

  task automatic t_settle();
    wr(4'd1, 8'h95);            // minutes enabled at 0x15, counters still match
    pulse_tick(); idle(2);
    flag_is("R8 one tick not enough", 1'b0);
    wr(4'd1, 8'h95);            // restart window
    pulse_tick(); idle(2);
    flag_is("R8 restart after rewrite", 1'b0);
    pulse_tick(); idle(1);
    flag_is("R8 flag after second tick", 1'b1);
    wr(4'd8, 8'h00);
  endtask

  task automatic t_year();
    wr(4'd0, 8'h30); wr(4'd1, 8'h15);   // mask seconds and minutes
    wr(4'd6, 8'h24); wr(4'd7, 8'h80);
    pulse_tick(); pulse_tick(); idle(2);
    flag_is("R4 year mismatch", 1'b0);
    cnt_year = 8'h24; @(negedge clk);
    flag_is("R4 year match", 1'b1);
    wr(4'd8, 8'h00);
    wr(4'd7, 8'h00);
    pulse_tick(); pulse_tick(); idle(2);
    cnt_year = 8'h25; @(negedge clk);
    cnt_year = 8'h24; @(negedge clk);
    flag_is("R9 nothing enabled", 1'b0);
  endtask

  initial begin
    #(8 * 100000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    idle(2);
    t_reset();
    rst_n = 1'b1;
    idle(1);
    t_regs();
    t_match();
    t_settle();
    t_year();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule